// File: doc/BRIEF.md
# Serial Port Pin Assignment Controller

This block sits between nine shared serial pins and the engines that use them: a synchronous serial (SPI) engine, an asynchronous transmitter/receiver (UART), and plain general-purpose I/O. Software configures it through three 8-bit registers. The first holds output values and reads back live pin levels. The second decides, pin by pin, whether the SPI engine or the general-purpose data register drives a pin. The third sets each pin as an input or an output.

For each drivable pin the block produces a registered drive value, output enable and open-drain flag for the pad. It also returns the sampled pin levels to the serial engines. Two pins follow fixed rules instead of the ownership register. The UART transmit pin belongs to the transmitter whenever it is enabled. The receive pin is always an input for the UART.

Pin bit positions, used by every register and pad vector: 0 MISO, 1 MOSI, 2 SCK, 3..6 chip-select 0..3, 7 TXD, 8 RXD (input only).

Top module: `pin_port_ctrl`

## Requirements
- R1: After reset every pad output enable and drive value is 0, and the ownership and direction registers read 0.
- R2: An ownership bit of 1 routes the SPI engine's value to that pin, and 0 routes the data register bit. Bits 0, 1 and 3..6 are implemented. Bits 2 and 7 are not stored and read 0.
- R3: The SCK pin (bit 2) is driven by the SPI engine while `spiEnable` is 1 and by the data register otherwise.
- R4: While `uartTxEn` is 1, pin 7 is enabled as an output carrying `uartTxData`, and its direction bit is ignored.
- R5: While `uartTxEn` is 0, pin 7 is enabled by its direction bit and driven from data register bit 7.
- R6: A direction bit of 1 enables the pad output and 0 disables it. This also holds for pins owned by the SPI engine.
- R7: A data register write changes only the bits whose direction bit is 1. The other bits keep their previous value.
- R8: Reading the data register (select 0) returns the live levels of pins 0..7. Select 1 reads the ownership register, select 2 the direction register, and select 3 reads 0 and writes nothing.
- R9: With `wiredOrSpi` set, pins 0..6 are open-drain. The open-drain flag is 1, the drive value is 0, and the output is enabled only when the value to send is 0.
- R10: With `wiredOrUart` set, pin 7 follows the same open-drain rule, whichever source drives it.
- R11: `spiIn` carries pad levels 0..6 and `uartRxd` carries pad level 8, with no delay.
- R12: Pad outputs are registered. A register write that takes effect at clock edge N shows on the pads after edge N+1, and an engine input change shows after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 data, 1 ownership, 2 direction |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| spiEnable | input | 1 | SPI engine running; claims SCK |
| spiOut | input | 7 | SPI engine values for pins 0..6 |
| spiIn | output | 7 | Pad levels of pins 0..6 to the SPI engine |
| wiredOrSpi | input | 1 | Open-drain mode for pins 0..6 |
| uartTxEn | input | 1 | Transmitter enable; claims pin 7 |
| uartTxData | input | 1 | Transmitter serial value |
| uartRxd | output | 1 | Pad level of pin 8 to the receiver |
| wiredOrUart | input | 1 | Open-drain mode for pin 7 |
| padIn | input | 9 | Sampled pad levels |
| padOut | output | 8 | Registered pad drive values |
| padOe | output | 8 | Registered pad output enables |
| padOd | output | 8 | Registered open-drain flags |

## Verification
The assertions check four rules on every cycle. No pad ever drives a 1 while its open-drain flag is set. Enabled output pins 0..6 always trace back to a set direction bit. Data register bits of input pins never change. An enabled push-pull transmitter always owns pin 7 one cycle later. The bench scenarios show the parts that depend on a sequence of configuration: which source wins for each ownership setting and SCK state, the masked data write seen after the direction changes, read-back of registers and pin levels, open-drain behaviour on both groups, and the exact one-cycle pad latency after a write.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int SPI_PINS  = 7;
  localparam int GPIO_PINS = 8;
  localparam int ALL_PINS  = GPIO_PINS + 1;
  localparam int REG_W     = GPIO_PINS;
  localparam int PIN_SCK   = 2;
  localparam int PIN_TXD   = SPI_PINS;
  localparam int PIN_RXD   = GPIO_PINS;
  // ownership bits exist only for SPI pins other than SCK
  localparam logic [REG_W-1:0] ASSIGN_MASK = REG_W'(((1 << SPI_PINS) - 1) & ~(1 << PIN_SCK));

  typedef enum logic [1:0] {
    SEL_DATA   = 2'd0,
    SEL_ASSIGN = 2'd1,
    SEL_DIR    = 2'd2,
    SEL_NONE   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic             wrData;
    logic             wrAssign;
    logic             wrDir;
    regSel_e          rdSel;
    logic [REG_W-1:0] wdata;
  } strobe_t;
endpackage

// File: rtl/pin_ctrl.sv
module pin_ctrl
  import pinmux_pkg::*;
(
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [REG_W-1:0] regWrData,
  output strobe_t          strobe
);
  regSel_e sel;

  always_comb begin
    sel             = regSel_e'(regSel);
    strobe.rdSel    = sel;
    strobe.wdata    = regWrData;
    strobe.wrData   = regWrEn && (sel == SEL_DATA);
    strobe.wrAssign = regWrEn && (sel == SEL_ASSIGN);
    strobe.wrDir    = regWrEn && (sel == SEL_DIR);
  end

  // R8: at most one register written per cycle
  always_comb begin
    a_r8_one_write: assert ($countones({strobe.wrData, strobe.wrAssign, strobe.wrDir}) <= 1);
  end
endmodule

// File: rtl/pin_datapath.sv
module pin_datapath
  import pinmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 spiEnable,
  input  logic [SPI_PINS-1:0]  spiOut,
  input  logic                 wiredOrSpi,
  input  logic                 uartTxEn,
  input  logic                 uartTxData,
  input  logic                 wiredOrUart,
  input  logic [ALL_PINS-1:0]  padIn,
  output logic [GPIO_PINS-1:0] padOut,
  output logic [GPIO_PINS-1:0] padOe,
  output logic [GPIO_PINS-1:0] padOd
);
  logic [REG_W-1:0]     dataReg, assignReg, dirReg;
  logic [GPIO_PINS-1:0] srcVal, srcOe, srcOd, nextOut, nextOe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg   <= '0;
      assignReg <= '0;
      dirReg    <= '0;
    end else begin
      if (strobe.wrData)   dataReg   <= (strobe.wdata & dirReg) | (dataReg & ~dirReg);
      if (strobe.wrAssign) assignReg <= strobe.wdata & ASSIGN_MASK;
      if (strobe.wrDir)    dirReg    <= strobe.wdata;
    end
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_DATA:   regRdData = padIn[REG_W-1:0];
      SEL_ASSIGN: regRdData = assignReg;
      SEL_DIR:    regRdData = dirReg;
      default:    regRdData = '0;
    endcase
  end

  for (genvar i = 0; i < SPI_PINS; i++) begin : g_spiPin
    logic spiOwns;
    if (i == PIN_SCK) begin : g_sck
      assign spiOwns = spiEnable;
    end else begin : g_assigned
      assign spiOwns = assignReg[i];
    end
    assign srcVal[i] = spiOwns ? spiOut[i] : dataReg[i];
    assign srcOe[i]  = dirReg[i];
    assign srcOd[i]  = wiredOrSpi;
  end

  assign srcVal[PIN_TXD] = uartTxEn ? uartTxData : dataReg[PIN_TXD];
  assign srcOe[PIN_TXD]  = uartTxEn | dirReg[PIN_TXD];
  assign srcOd[PIN_TXD]  = wiredOrUart;

  for (genvar p = 0; p < GPIO_PINS; p++) begin : g_drive
    assign nextOut[p] = srcOd[p] ? 1'b0 : srcVal[p];
    assign nextOe[p]  = srcOe[p] & (srcOd[p] ? ~srcVal[p] : 1'b1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      padOut <= '0;
      padOe  <= '0;
      padOd  <= '0;
    end else begin
      padOut <= nextOut;
      padOe  <= nextOe;
      padOd  <= srcOd;
    end
  end

  // R9/R10: an open-drain pad never drives high
  a_r9_od_never_high: assert property (@(posedge clk) disable iff (!rstN)
    (padOd & padOe & padOut) == '0);
  // R6: enabled SPI-group pads come from a set direction bit
  a_r6_oe_needs_dir: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (padOe[SPI_PINS-1:0] & ~$past(dirReg[SPI_PINS-1:0])) == '0);
  // R7: input-pin data bits never change
  a_r7_masked_data: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((dataReg ^ $past(dataReg)) & ~$past(dirReg)) == '0);
  // R4: enabled push-pull transmitter owns pin 7
  a_r4_txd_claimed: assert property (@(posedge clk) disable iff (!rstN)
    (uartTxEn && !wiredOrUart) |=> padOe[PIN_TXD] && (padOut[PIN_TXD] == $past(uartTxData)));
endmodule

// File: rtl/pin_port_ctrl.sv
module pin_port_ctrl
  import pinmux_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [1:0]           regSel,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     regRdData,
  input  logic                 spiEnable,
  input  logic [SPI_PINS-1:0]  spiOut,
  output logic [SPI_PINS-1:0]  spiIn,
  input  logic                 wiredOrSpi,
  input  logic                 uartTxEn,
  input  logic                 uartTxData,
  output logic                 uartRxd,
  input  logic                 wiredOrUart,
  input  logic [ALL_PINS-1:0]  padIn,
  output logic [GPIO_PINS-1:0] padOut,
  output logic [GPIO_PINS-1:0] padOe,
  output logic [GPIO_PINS-1:0] padOd
);
  strobe_t strobe;

  pin_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regSel    (regSel),
    .regWrData (regWrData),
    .strobe    (strobe)
  );

  pin_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .regRdData   (regRdData),
    .spiEnable   (spiEnable),
    .spiOut      (spiOut),
    .wiredOrSpi  (wiredOrSpi),
    .uartTxEn    (uartTxEn),
    .uartTxData  (uartTxData),
    .wiredOrUart (wiredOrUart),
    .padIn       (padIn),
    .padOut      (padOut),
    .padOe       (padOe),
    .padOd       (padOd)
  );

  assign spiIn   = padIn[SPI_PINS-1:0];
  assign uartRxd = padIn[PIN_RXD];
endmodule

// File: tb/pin_port_ctrl_tb.sv
module pin_port_ctrl_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       spiEnable = 1'b0;
  logic [6:0] spiOut = 7'h00;
  logic [6:0] spiIn;
  logic       wiredOrSpi = 1'b0;
  logic       uartTxEn = 1'b0;
  logic       uartTxData = 1'b0;
  logic       uartRxd;
  logic       wiredOrUart = 1'b0;
  logic [8:0] padIn = 9'h000;
  logic [7:0] padOut, padOe, padOd;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  pin_port_ctrl u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .regRdData(regRdData), .spiEnable(spiEnable),
    .spiOut(spiOut), .spiIn(spiIn), .wiredOrSpi(wiredOrSpi),
    .uartTxEn(uartTxEn), .uartTxData(uartTxData), .uartRxd(uartRxd),
    .wiredOrUart(wiredOrUart), .padIn(padIn), .padOut(padOut),
    .padOe(padOe), .padOd(padOd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // write lands at one edge; returns at the following negedge
  task automatic writeReg(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [7:0] val);
    regSel = sel;
    #1 val = regRdData;
  endtask

  task automatic tReset();
    logic [7:0] v;
    check("R1 padOe", padOe, 8'h00);
    check("R1 padOut", padOut, 8'h00);
    readReg(2'd1, v); check("R1 assign", v, 8'h00);
    readReg(2'd2, v); check("R1 dir", v, 8'h00);
  endtask

  task automatic tDataMask();
    writeReg(2'd0, 8'hFF);          // all inputs: nothing stored
    writeReg(2'd2, 8'h7F);
    settle();
    check("R7 masked write", padOut, 8'h00);
    check("R6 dir enables", padOe, 8'h7F);
    writeReg(2'd0, 8'h55);
    settle();
    check("R5 gpio data", padOut, 8'h55);
  endtask

  task automatic tLatency();
    writeReg(2'd0, 8'h2A);
    check("R12 not yet", padOut, 8'h55);
    settle();
    check("R12 after edge", padOut, 8'h2A);
  endtask

  task automatic tAssign();
    logic [7:0] v;
    spiOut = 7'h5D;
    writeReg(2'd1, 8'hFF);
    readReg(2'd1, v); check("R2 implemented bits", v, 8'h7B);
    settle();
    check("R2 spi owned", padOut[6:0], 7'h59);
    writeReg(2'd2, 8'h00);
    settle();
    check("R6 spi pins need dir", padOe, 8'h00);
    writeReg(2'd2, 8'h7F);
    settle();
  endtask

  task automatic tSck();
    spiEnable = 1'b1;
    settle();
    check("R3 sck to spi", padOut[6:0], 7'h5D);
    spiEnable = 1'b0;
    settle();
    check("R3 sck to gpio", padOut[6:0], 7'h59);
  endtask

  task automatic tTxd();
    uartTxEn = 1'b1; uartTxData = 1'b1;
    settle();
    check("R4 txd oe", padOe[7], 1'b1);
    check("R4 txd high", padOut[7], 1'b1);
    uartTxData = 1'b0;
    settle();
    check("R4 txd low", padOut[7], 1'b0);
    uartTxEn = 1'b0;
    settle();
    check("R5 txd released", padOe[7], 1'b0);
    writeReg(2'd2, 8'hFF);
    writeReg(2'd0, 8'h80);
    settle();
    check("R5 txd gpio oe", padOe[7], 1'b1);
    check("R5 txd gpio val", padOut[7], 1'b1);
  endtask

  task automatic tWiredOr();
    writeReg(2'd1, 8'h00);
    writeReg(2'd0, 8'h0F);
    wiredOrSpi = 1'b1;
    settle();
    check("R9 od drive zero", padOut[6:0], 7'h00);
    check("R9 od oe", padOe[6:0], 7'h70);
    check("R9 od flag", padOd, 8'h7F);
    wiredOrUart = 1'b1;
    settle();
    check("R10 txd od low", {padOd[7], padOe[7], padOut[7]}, 3'b110);
    uartTxEn = 1'b1; uartTxData = 1'b1;
    settle();
    check("R10 txd od release", {padOd[7], padOe[7], padOut[7]}, 3'b100);
    uartTxEn = 1'b0; wiredOrUart = 1'b0; wiredOrSpi = 1'b0;
  endtask

  task automatic tReadPins();
    logic [7:0] v;
    padIn = 9'h1A5;
    readReg(2'd0, v); check("R8 pin levels", v, 8'hA5);
    readReg(2'd3, v); check("R8 select 3", v, 8'h00);
    check("R11 spiIn", spiIn, 7'h25);
    check("R11 uartRxd", uartRxd, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    settle();
    tReset();
    tDataMask();
    tLatency();
    tAssign();
    tSck();
    tTxd();
    tWiredOr();
    tReadPins();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #100000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule